// File: doc/BRIEF.md
# Step Command and Encoder Feedback Error Monitor

This block supervises one motor axis that is driven by a step line and a direction line. It keeps two signed position counts side by side: one is built from the step pulses the upstream pulse generator issues, signed by the command direction, and the other is built from the pulses an encoder returns, signed by the encoder's own direction line. The host reads the difference of the two counts as the following error of the axis.

While correction is enabled and the error is not zero, the block issues its own correction steps with a matching direction, toward a smaller error. A programmable clock gap sets how often these steps may come. A travel limit or an alarm blocks correction in the direction it guards. The limit, alarm, home and drive-ready inputs are synchronized and gathered into a status byte. That byte also holds sticky flags for both limits and the alarm, and the host clears those flags by writing ones.

All encoder and supervision inputs are asynchronous and pass through a flop synchronizer. The step command is in the block's own clock domain. A host strobe zeroes both counts in one clock.

Top module: `step_loop_monitor`

## Requirements
- R1: Each rising edge of `cmd_step` changes `cmd_count` by exactly one on that clock edge, +1 when `cmd_dir` is 1 and -1 when it is 0; a step level held high is counted once.
- R2: Each rising edge of the synchronized `enc_pulse` changes `fb_count` by one, +1 when the synchronized `enc_dir` is 1 and -1 when it is 0, at most SYNC_STAGES+1 clocks after the input rises.
- R3: `pos_err` equals `cmd_count - fb_count` in CNT_W-bit two's complement, and both counters wrap (one reverse step from zero gives all ones).
- R4: A one-clock `host_clear` sets both counters to zero at the next clock edge, and a step counted on that same edge is discarded.
- R5: A correction step comes only while `corr_en` is 1 and `pos_err` is nonzero; `corr_dir` is 1 with a step issued for a positive error and 0 for a negative one.
- R6: `corr_step` is high for one clock per step, and steps issued while correction stays eligible begin exactly max(`corr_gap`, 2) clocks apart.
- R7: No correction step with `corr_dir` 1 is issued while the positive limit or the alarm is active, and none with `corr_dir` 0 while the negative limit or the alarm is active.
- R8: `status` bits 0..4 follow the synchronized positive limit, negative limit, alarm, home and drive-ready inputs; bits 5, 6 and 7 are sticky copies of the positive limit, negative limit and alarm.
- R9: Sticky bit 5+k of `status` is cleared by a clock with `sticky_clr[k]` at 1, unless its source is still active, in which case it stays set; all `status` bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_step | input | 1 | Step pulse from the pulse generator (clock domain) |
| cmd_dir | input | 1 | Command direction, 1 = forward |
| enc_pulse | input | 1 | Encoder count pulse (asynchronous) |
| enc_dir | input | 1 | Encoder direction, 1 = forward (asynchronous) |
| lim_pos | input | 1 | Positive travel limit, active high (asynchronous) |
| lim_neg | input | 1 | Negative travel limit, active high (asynchronous) |
| alarm | input | 1 | Drive alarm, active high (asynchronous) |
| home | input | 1 | Zero-position sensor, active high (asynchronous) |
| servo_rdy | input | 1 | Drive ready, active high (asynchronous) |
| host_clear | input | 1 | Strobe that zeroes both counters |
| corr_en | input | 1 | Enables correction steps |
| corr_gap | input | GAP_W | Minimum clocks between correction steps |
| sticky_clr | input | 3 | Write-one-to-clear strobes for the sticky status bits |
| cmd_count | output | CNT_W | Signed commanded position count |
| fb_count | output | CNT_W | Signed feedback position count |
| pos_err | output | CNT_W | Signed following error, command minus feedback |
| corr_step | output | 1 | Correction step pulse |
| corr_dir | output | 1 | Correction direction, 1 = forward |
| status | output | 8 | Live and sticky supervision flags |

## Verification
A table of step vectors drives command steps alone, encoder pulses alone and both at once, in both directions, and crosses zero so that the counts and the error wrap. This separates a sign error on either count from a wrong subtraction order in the error. Directed runs then hold a positive, a negative and a zero error under correction, with long and short gaps, to tell a wrong direction from a wrong spacing or a pulse wider than one clock. The limit and alarm runs pair each blocked case with an unblocked one, so that a missing block and a block applied to the wrong side both show up. A clear that lands on a step edge shows whether clear wins, and sticky clears are tried with the source both gone and still active.

// File: rtl/slm_pkg.sv
package slm_pkg;
   // status byte layout
   localparam int ST_LIM_POS = 0;
   localparam int ST_LIM_NEG = 1;
   localparam int ST_ALARM   = 2;
   localparam int ST_HOME    = 3;
   localparam int ST_SRDY    = 4;
   localparam int ST_STK0    = 5;
   localparam int STATUS_W   = 8;
   localparam int N_STICKY   = 3;

   // order of the synchronized asynchronous inputs
   localparam int IN_ENC_P = 0;
   localparam int IN_ENC_D = 1;
   localparam int IN_LIM_P = 2;
   localparam int IN_LIM_N = 3;
   localparam int IN_ALM   = 4;
   localparam int IN_HOME  = 5;
   localparam int IN_SRDY  = 6;
   localparam int N_ASYNC  = 7;

   typedef enum logic {DIR_REV = 1'b0, DIR_FWD = 1'b1} dir_e;
endpackage

// File: rtl/slm_sync.sv
module slm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("slm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/slm_edge_counter.sv
module slm_edge_counter
   import slm_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             pulse,
   input  logic             dir,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic pulse_prev;
   logic rise;

   assign rise = pulse & ~pulse_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_prev <= 1'b0;
         count      <= '0;
      end else begin
         pulse_prev <= pulse;
         if (clr)
            count <= '0;
         else if (rise)
            count <= (dir_e'(dir) == DIR_FWD) ? count + ONE : count - ONE;
      end
   end
endmodule

// File: rtl/slm_corrector.sv
module slm_corrector #(
   parameter int CNT_W = 32,
   parameter int GAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] err,
   input  logic [GAP_W-1:0] gap,
   input  logic             blk_fwd,
   input  logic             blk_rev,
   output logic             step,
   output logic             dir
);
   localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);
   localparam logic [GAP_W-1:0] GAP_MAX = '1;

   logic [GAP_W-1:0] timer;
   logic             err_nz;
   logic             want_fwd;
   logic             blocked;
   logic             fire;

   assign err_nz   = |err;
   assign want_fwd = ~err[CNT_W-1];
   assign blocked  = want_fwd ? blk_fwd : blk_rev;
   assign fire     = en & err_nz & ~blocked & ~step & (timer >= gap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer <= '0;
         step  <= 1'b0;
         dir   <= 1'b0;
      end else begin
         step <= fire;
         if (fire) begin
            timer <= GAP_ONE;
            dir   <= want_fwd;
         end else if (timer != GAP_MAX) begin
            timer <= timer + GAP_ONE;
         end
      end
   end
endmodule

// File: rtl/slm_status.sv
module slm_status
   import slm_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lim_p,
   input  logic                lim_n,
   input  logic                alm,
   input  logic                hom,
   input  logic                rdy,
   input  logic [N_STICKY-1:0] clr,
   output logic [STATUS_W-1:0] status
);
   logic [N_STICKY-1:0] sticky;
   logic [N_STICKY-1:0] src;

   assign src = {alm, lim_n, lim_p};

   for (genvar k = 0; k < N_STICKY; k++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sticky[k] <= 1'b0;
         else        sticky[k] <= (sticky[k] & ~clr[k]) | src[k];
      end
   end

   always_comb begin
      status             = '0;
      status[ST_LIM_POS] = lim_p;
      status[ST_LIM_NEG] = lim_n;
      status[ST_ALARM]   = alm;
      status[ST_HOME]    = hom;
      status[ST_SRDY]    = rdy;
      status[ST_STK0 +: N_STICKY] = sticky;
   end
endmodule

// File: rtl/step_loop_monitor.sv
module step_loop_monitor
   import slm_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int GAP_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_step,
   input  logic             cmd_dir,
   input  logic             enc_pulse,
   input  logic             enc_dir,
   input  logic             lim_pos,
   input  logic             lim_neg,
   input  logic             alarm,
   input  logic             home,
   input  logic             servo_rdy,
   input  logic             host_clear,
   input  logic             corr_en,
   input  logic [GAP_W-1:0] corr_gap,
   input  logic [2:0]       sticky_clr,
   output logic [CNT_W-1:0] cmd_count,
   output logic [CNT_W-1:0] fb_count,
   output logic [CNT_W-1:0] pos_err,
   output logic             corr_step,
   output logic             corr_dir,
   output logic [7:0]       status
);
   localparam int N_CNT = 2;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("step_loop_monitor: CNT_W must be at least 2");
   end
   if (GAP_W < 2) begin : g_bad_gap
      $error("step_loop_monitor: GAP_W must be at least 2");
   end
   if (STATUS_W != 8 || N_STICKY != 3) begin : g_bad_pkg
      $error("step_loop_monitor: status layout does not match the port widths");
   end

   logic [N_ASYNC-1:0] raw_in;
   logic [N_ASYNC-1:0] syn;

   assign raw_in[IN_ENC_P] = enc_pulse;
   assign raw_in[IN_ENC_D] = enc_dir;
   assign raw_in[IN_LIM_P] = lim_pos;
   assign raw_in[IN_LIM_N] = lim_neg;
   assign raw_in[IN_ALM]   = alarm;
   assign raw_in[IN_HOME]  = home;
   assign raw_in[IN_SRDY]  = servo_rdy;

   slm_sync #(.W(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   // index 0: command count, index 1: feedback count
   logic [N_CNT-1:0] cnt_pulse;
   logic [N_CNT-1:0] cnt_dir;
   logic [CNT_W-1:0] cnt_val [N_CNT];

   assign cnt_pulse = {syn[IN_ENC_P], cmd_step};
   assign cnt_dir   = {syn[IN_ENC_D], cmd_dir};

   for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
      slm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (host_clear),
         .pulse (cnt_pulse[i]),
         .dir   (cnt_dir[i]),
         .count (cnt_val[i])
      );
   end

   assign cmd_count = cnt_val[0];
   assign fb_count  = cnt_val[1];
   assign pos_err   = cnt_val[0] - cnt_val[1];

   slm_corrector #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_corr (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (corr_en),
      .err     (pos_err),
      .gap     (corr_gap),
      .blk_fwd (syn[IN_LIM_P] | syn[IN_ALM]),
      .blk_rev (syn[IN_LIM_N] | syn[IN_ALM]),
      .step    (corr_step),
      .dir     (corr_dir)
   );

   slm_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .lim_p  (syn[IN_LIM_P]),
      .lim_n  (syn[IN_LIM_N]),
      .alm    (syn[IN_ALM]),
      .hom    (syn[IN_HOME]),
      .rdy    (syn[IN_SRDY]),
      .clr    (sticky_clr),
      .status (status)
   );
endmodule

// File: rtl/slm_checker.sv
module slm_checker #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_clear,
   input logic             corr_en,
   input logic [CNT_W-1:0] cmd_count,
   input logic [CNT_W-1:0] fb_count,
   input logic [CNT_W-1:0] pos_err,
   input logic             corr_step,
   input logic             corr_dir,
   input logic [7:0]       status
);
   // R4: clear leaves both counters at zero after the edge
   assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      host_clear |=> (cmd_count == '0 && fb_count == '0));

   // R5: a correction step needs a nonzero error and enable in the cycle before
   assert_step_needs_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(corr_step) |-> ($past(pos_err) != '0 && $past(corr_en)));

   // R5: direction matches the sign of the error that triggered the step
   assert_step_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(corr_step) |-> (corr_dir == ~$past(pos_err[CNT_W-1])));

   // R6: a correction step lasts one clock
   assert_single_clock_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      corr_step |=> !corr_step);

   // R7: no forward step while the positive limit or the alarm was reported
   assert_fwd_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(corr_step) && corr_dir) |-> !($past(status[0]) || $past(status[2])));

   // R7: no reverse step while the negative limit or the alarm was reported
   assert_rev_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(corr_step) && !corr_dir) |-> !($past(status[1]) || $past(status[2])));

   // R8: an active alarm is caught by its sticky flag
   assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status[2] |=> status[7]);
endmodule

bind step_loop_monitor slm_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_clear (host_clear),
   .corr_en    (corr_en),
   .cmd_count  (cmd_count),
   .fb_count   (fb_count),
   .pos_err    (pos_err),
   .corr_step  (corr_step),
   .corr_dir   (corr_dir),
   .status     (status)
);

// File: tb/step_loop_monitor_tb.sv
module step_loop_monitor_tb;
   localparam int CNT_W = 32;
   localparam int GAP_W = 16;
   localparam int NV    = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_step = 0, cmd_dir = 0, enc_pulse = 0, enc_dir = 0;
   logic             lim_pos = 0, lim_neg = 0, alarm = 0, home = 0, servo_rdy = 0;
   logic             host_clear = 0, corr_en = 0;
   logic [GAP_W-1:0] corr_gap = '0;
   logic [2:0]       sticky_clr = '0;
   logic [CNT_W-1:0] cmd_count, fb_count, pos_err;
   logic             corr_step, corr_dir;
   logic [7:0]       status;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   step_loop_monitor #(.CNT_W(CNT_W), .GAP_W(GAP_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_step(cmd_step), .cmd_dir(cmd_dir),
      .enc_pulse(enc_pulse), .enc_dir(enc_dir), .lim_pos(lim_pos), .lim_neg(lim_neg),
      .alarm(alarm), .home(home), .servo_rdy(servo_rdy), .host_clear(host_clear),
      .corr_en(corr_en), .corr_gap(corr_gap), .sticky_clr(sticky_clr),
      .cmd_count(cmd_count), .fb_count(fb_count), .pos_err(pos_err),
      .corr_step(corr_step), .corr_dir(corr_dir), .status(status)
   );

   // {do_cmd, cmd_dir, do_enc, enc_dir, exp_cmd, exp_fb, exp_err}
   localparam logic [99:0] VEC [NV] = '{
      {1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
      {1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0002, 32'h0000_0000, 32'h0000_0002},
      {1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0002, 32'h0000_0001, 32'h0000_0001},
      {1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0002, 32'h0000_0000, 32'h0000_0002},
      {1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
      {1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF},
      {1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'hFFFF_FFFE},
      {1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step_both(input logic dc, input logic cd, input logic de, input logic ed);
      @(negedge clk);
      cmd_dir = cd;
      enc_dir = ed;
      @(negedge clk);
      cmd_step  = dc;
      enc_pulse = de;
      repeat (2) @(negedge clk);
      cmd_step  = 0;
      enc_pulse = 0;
      repeat (5) @(negedge clk);
   endtask

   task automatic clear_counts();
      @(negedge clk);
      host_clear = 1;
      @(negedge clk);
      host_clear = 0;
   endtask

   // watch corr_step for n cycles at negedges
   task automatic watch(input int n, output int pulses, output int spacing,
                        output logic first_dir, output logic wide);
      int first_at;
      logic prev;
      pulses = 0; spacing = -1; first_at = -1; first_dir = 1'bx; wide = 0; prev = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (corr_step) begin
            if (prev) wide = 1;
            else begin
               pulses++;
               if (first_at < 0) begin
                  first_at  = k;
                  first_dir = corr_dir;
               end else if (spacing < 0) spacing = k - first_at;
            end
         end
         prev = corr_step;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int np, sp;
      logic fd, wd;
      logic [99:0] v;

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state, R9 status zero
      chk("R1 reset cmd_count", cmd_count, 0);
      chk("R2 reset fb_count", fb_count, 0);
      chk("R5 reset corr_step", {31'd0, corr_step}, 0);
      chk("R9 reset status", {24'd0, status}, 0);

      // vector table: R1 R2 R3
      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         step_both(v[99], v[98], v[97], v[96]);
         chk($sformatf("R1 vec%0d cmd_count", i), cmd_count, v[95:64]);
         chk($sformatf("R2 vec%0d fb_count", i), fb_count, v[63:32]);
         chk($sformatf("R3 vec%0d pos_err", i), pos_err, v[31:0]);
      end

      // R1: count lands on the first edge with the step high
      @(negedge clk);
      cmd_dir = 1;
      cmd_step = 1;
      @(negedge clk);
      chk("R1 same-edge count", cmd_count, 32'h0000_0000);
      cmd_step = 0;

      // R4: clear on the same edge as a step rise
      @(negedge clk);
      cmd_dir = 1;
      cmd_step = 1;
      host_clear = 1;
      @(negedge clk);
      host_clear = 0;
      chk("R4 clear beats step cmd", cmd_count, 0);
      chk("R4 clear fb", fb_count, 0);
      @(negedge clk);
      cmd_step = 0;
      @(negedge clk);
      chk("R4 held step not recounted", cmd_count, 0);

      // R5 R6: positive error, gap 5
      repeat (3) step_both(1, 1, 0, 0);
      chk("R3 err before correction", pos_err, 3);
      corr_gap = 5;
      corr_en = 1;
      watch(30, np, sp, fd, wd);
      chk("R5 pulses with positive error", {31'd0, np > 0}, 1);
      chk("R5 dir for positive error", {31'd0, fd}, 1);
      chk("R6 spacing gap5", sp, 5);
      chk("R6 one-clock pulses", {31'd0, wd}, 0);

      // R6: gap 0 gives spacing 2
      corr_en = 0;
      corr_gap = 0;
      repeat (3) @(negedge clk);
      corr_en = 1;
      watch(20, np, sp, fd, wd);
      chk("R6 spacing gap0", sp, 2);
      chk("R6 one-clock pulses gap0", {31'd0, wd}, 0);

      // R5: disabled
      corr_en = 0;
      repeat (2) @(negedge clk);
      watch(20, np, sp, fd, wd);
      chk("R5 no pulses when disabled", np, 0);

      // R7: positive limit blocks forward
      corr_gap = 3;
      lim_pos = 1;
      repeat (4) @(negedge clk);
      corr_en = 1;
      watch(20, np, sp, fd, wd);
      chk("R7 fwd blocked by lim_pos", np, 0);
      corr_en = 0;
      lim_pos = 0;
      lim_neg = 1;
      repeat (4) @(negedge clk);
      corr_en = 1;
      watch(20, np, sp, fd, wd);
      chk("R7 fwd allowed under lim_neg", {31'd0, np > 0}, 1);
      corr_en = 0;
      lim_neg = 0;

      // negative error
      clear_counts();
      repeat (2) step_both(1, 0, 0, 0);
      chk("R3 negative err", pos_err, 32'hFFFF_FFFE);
      alarm = 1;
      repeat (4) @(negedge clk);
      corr_en = 1;
      watch(20, np, sp, fd, wd);
      chk("R7 rev blocked by alarm", np, 0);
      corr_en = 0;
      alarm = 0;
      repeat (4) @(negedge clk);
      corr_en = 1;
      watch(20, np, sp, fd, wd);
      chk("R5 pulses with negative error", {31'd0, np > 0}, 1);
      chk("R5 dir for negative error", {31'd0, fd}, 0);
      corr_en = 0;

      // zero error
      clear_counts();
      corr_en = 1;
      watch(20, np, sp, fd, wd);
      chk("R5 no pulses at zero error", np, 0);
      corr_en = 0;

      // status R8 R9
      @(negedge clk);
      sticky_clr = 3'b111;
      @(negedge clk);
      sticky_clr = 0;
      @(negedge clk);
      chk("R9 sticky cleared", {24'd0, status}, 0);
      lim_neg = 1; home = 1; servo_rdy = 1;
      repeat (4) @(negedge clk);
      chk("R8 live and sticky bits", {24'd0, status}, 32'h5A);
      lim_neg = 0; home = 0; servo_rdy = 0;
      repeat (4) @(negedge clk);
      chk("R8 sticky kept", {24'd0, status}, 32'h40);
      sticky_clr = 3'b010;
      @(negedge clk);
      sticky_clr = 0;
      @(negedge clk);
      chk("R9 write-one clear", {24'd0, status}, 0);
      alarm = 1;
      repeat (4) @(negedge clk);
      chk("R8 alarm bits", {24'd0, status}, 32'h84);
      sticky_clr = 3'b100;
      @(negedge clk);
      sticky_clr = 0;
      @(negedge clk);
      chk("R9 set wins over clear", {24'd0, status}, 32'h84);
      alarm = 0;
      repeat (4) @(negedge clk);
      chk("R8 alarm sticky after release", {24'd0, status}, 32'h80);
      lim_pos = 1;
      repeat (4) @(negedge clk);
      chk("R8 pos limit bits", {24'd0, status}, 32'hA1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule